// File: doc/BRIEF.md
# GF(2) Hash Signature Generator

This block squeezes a wide vector of monitored state bits into a narrow signature word on every enabled clock cycle. A word-granular concentrator first picks which bytes of the monitored vector take part. The signature is then the product of a fixed sparse binary matrix and the concentrated vector over GF(2). Each signature bit is therefore the XOR of a small, fixed subset of the concentrated bits.

The matrix rows are a parameter. For the hash to be usable they must form a full-rank matrix, and each row should set only a few bits, which keeps every XOR tree shallow. The concentrator's routing table sits in a register that is loaded bit by bit through a serial port. This allows the monitored words to be changed between debug runs without touching the hash.

Top module: `sig_hash_gen`

## Requirements
- R1: After reset, `sig_out` is zero and `sig_valid` is low. The routing table maps slot k to source word k.
- R2: Concentrated slot k occupies bits [8k+7:8k] of the hashed vector. It carries source word i, which is `mon_vec[8i+7:8i]`, where i is the 4-bit index held in routing-table bits [4k+3:4k].
- R3: A routing index equal to or greater than the number of source words (8 by default) feeds an all-zero byte into its slot.
- R4: Signature bit r is the XOR of every concentrated bit b for which bit b of matrix row r is set.
- R5: When `mon_en` is high and `cfg_shift` is low at a clock edge, `sig_out` shows the signature of the `mon_vec` sampled at that edge from the next cycle on, and `sig_valid` is high.
- R6: When `mon_en` is low at an edge, `sig_valid` goes low and `sig_out` keeps its previous value.
- R7: At each edge with `cfg_shift` high, `cfg_sdi` enters routing-table bit 15 and the existing bits move one place toward bit 0. After 16 shifts, the first bit shifted in sits in bit 0. The new table governs the next enabled cycle.
- R8: At an edge with `cfg_shift` high, `sig_valid` goes low and `sig_out` is held, even when `mon_en` is high.
- R9: The signature is linear: the signature of a XOR b equals the XOR of the signatures of a and b under the same routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mon_vec | input | 64 | Monitored state vector, eight 8-bit source words |
| mon_en | input | 1 | Compress this cycle's vector |
| cfg_sdi | input | 1 | Serial routing-table data |
| cfg_shift | input | 1 | Shift `cfg_sdi` into the routing table |
| sig_out | output | 8 | Registered signature |
| sig_valid | output | 1 | `sig_out` was computed at the last edge |

## Verification
The bench loads routing tables that contain duplicate indices and out-of-range indices 8 and 15. A concentrator that wraps or truncates the index would leak a real source byte into a slot where the bench expects zero. Shift sequences are run with `mon_en` held high. A design that does not block capture during loading would raise `sig_valid` or change `sig_out` mid-load, and a design with the wrong shift direction would misroute every word after the load. Idle cycles check that the signature is held rather than cleared, and XOR-combined vectors expose any nonlinear term or wrong tap in the matrix trees.

// File: rtl/sig_hash_pkg.sv
// Shared constants for the signature generator.
// Assumes concentrator granularity is fixed at one byte.
package sig_hash_pkg;
    localparam int WORD_W = 8;
endpackage

// File: rtl/route_cfg_reg.sv
// Serially loaded routing table. Shifts toward bit 0, new bit in at the MSB.
// Assumes rst_n is synchronous and active low.
module route_cfg_reg #(
    parameter int               CFG_W     = 16,
    parameter logic [CFG_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdi,
    output logic [CFG_W-1:0] cfg
);
    // Load or hold the routing table.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg <= RESET_VAL;
        else if (shift_en) cfg <= {sdi, cfg[CFG_W-1:1]};
    end

    // R7: serial bit lands in the MSB
    p_shift_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> cfg[CFG_W-1] == $past(sdi));
    // R7: table is stable without a shift
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cfg));
endmodule

// File: rtl/word_concentrator.sv
// Routes whole source bytes into output slots by a per-slot index.
// Assumes indices at or above SRC_WORDS mean "no source" and yield zero.
module word_concentrator
    import sig_hash_pkg::*;
#(
    parameter int SRC_WORDS = 8,
    parameter int SEL_WORDS = 4,
    parameter int IDX_W     = 4,
    localparam int SRC_W    = SRC_WORDS * WORD_W,
    localparam int SEL_W    = SEL_WORDS * WORD_W,
    localparam int MAP_W    = SEL_WORDS * IDX_W
) (
    input  logic [SRC_W-1:0] src_vec,
    input  logic [MAP_W-1:0] sel_map,
    output logic [SEL_W-1:0] conc_vec
);
    for (genvar k = 0; k < SEL_WORDS; k++) begin : g_slot
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] slot;
        assign idx = sel_map[k*IDX_W +: IDX_W];

        // Pick the matching source byte, zero if none matches.
        always_comb begin
            slot = '0;
            for (int j = 0; j < SRC_WORDS; j++) begin
                if (idx == IDX_W'(j)) slot = src_vec[j*WORD_W +: WORD_W];
            end
        end
        assign conc_vec[k*WORD_W +: WORD_W] = slot;

        // R3: out-of-range index contributes a zero byte
        always_comb begin
            if (int'(idx) >= SRC_WORDS) begin
                p_oor_zero_r3: assert (conc_vec[k*WORD_W +: WORD_W] == '0);
            end
        end
    end
endmodule

// File: rtl/gf2_xor_matrix.sv
// GF(2) matrix-vector product: one XOR reduction tree per row.
// Assumes ROWS is sparse and full rank; both are left to whoever picks it.
module gf2_xor_matrix #(
    parameter int                          IN_W  = 32,
    parameter int                          OUT_W = 8,
    parameter logic [OUT_W-1:0][IN_W-1:0]  ROWS  = '0
) (
    input  logic [IN_W-1:0]  vec_in,
    output logic [OUT_W-1:0] sig
);
    for (genvar r = 0; r < OUT_W; r++) begin : g_row
        // Parity of the taps selected by this row.
        assign sig[r] = ^(vec_in & ROWS[r]);
    end

    // R4: a zero vector hashes to zero in a linear map
    always_comb begin
        if (vec_in == '0) begin
            p_zero_in_r4: assert (sig == '0);
        end
    end
endmodule

// File: rtl/sig_hash_gen.sv
// Top: routing table, byte concentrator, XOR matrix, signature register.
// Assumes HASH_ROWS is full rank; capture is blocked while the table loads.
module sig_hash_gen
    import sig_hash_pkg::*;
#(
    parameter int SRC_WORDS = 8,
    parameter int SEL_WORDS = 4,
    parameter int IDX_W     = 4,
    parameter int SIG_W     = 8,
    parameter logic [SIG_W-1:0][SEL_WORDS*WORD_W-1:0] HASH_ROWS = {
        32'h10804004, 32'h01080080, 32'h80102400, 32'h20010008,
        32'h02001040, 32'h00408102, 32'h40000210, 32'h08040021}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SRC_WORDS*WORD_W-1:0] mon_vec,
    input  logic                        mon_en,
    input  logic                        cfg_sdi,
    input  logic                        cfg_shift,
    output logic [SIG_W-1:0]            sig_out,
    output logic                        sig_valid
);
    localparam int SEL_W = SEL_WORDS * WORD_W;
    localparam int CFG_W = SEL_WORDS * IDX_W;

    // Identity routing: slot k takes source word k.
    function automatic logic [CFG_W-1:0] ident_map();
        logic [CFG_W-1:0] m = '0;
        for (int k = 0; k < SEL_WORDS; k++) m[k*IDX_W +: IDX_W] = IDX_W'(k);
        return m;
    endfunction
    localparam logic [CFG_W-1:0] CFG_RESET = ident_map();

    logic [CFG_W-1:0] route_map;
    logic [SEL_W-1:0] conc_vec;
    logic [SIG_W-1:0] sig_next;

    route_cfg_reg #(.CFG_W(CFG_W), .RESET_VAL(CFG_RESET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .shift_en(cfg_shift), .sdi(cfg_sdi), .cfg(route_map));

    word_concentrator #(.SRC_WORDS(SRC_WORDS), .SEL_WORDS(SEL_WORDS), .IDX_W(IDX_W)) u_conc (
        .src_vec(mon_vec), .sel_map(route_map), .conc_vec(conc_vec));

    gf2_xor_matrix #(.IN_W(SEL_W), .OUT_W(SIG_W), .ROWS(HASH_ROWS)) u_hash (
        .vec_in(conc_vec), .sig(sig_next));

    // Capture the signature on enabled cycles that are not loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_out   <= '0;
            sig_valid <= 1'b0;
        end else begin
            sig_valid <= mon_en && !cfg_shift;
            if (mon_en && !cfg_shift) sig_out <= sig_next;
        end
    end

    // R6: idle cycle holds the signature and drops valid
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !sig_valid && $stable(sig_out));
    // R8: loading blocks capture
    p_shift_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> !sig_valid && $stable(sig_out));
    // R5: valid only follows an enabled, non-loading edge
    p_valid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && !cfg_shift) |=> sig_valid);
endmodule

// File: tb/sig_hash_gen_tb.sv
module sig_hash_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0][31:0] ROWS = {
        32'h10804004, 32'h01080080, 32'h80102400, 32'h20010008,
        32'h02001040, 32'h00408102, 32'h40000210, 32'h08040021};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] mon_vec = '0;
    logic        mon_en = 1'b0;
    logic        cfg_sdi = 1'b0;
    logic        cfg_shift = 1'b0;
    logic [7:0]  sig_out;
    logic        sig_valid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_cfg;
    logic [7:0]  e_sig;
    logic        e_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_hash_gen #(.HASH_ROWS(ROWS)) u_dut (
        .clk(clk), .rst_n(rst_n), .mon_vec(mon_vec), .mon_en(mon_en),
        .cfg_sdi(cfg_sdi), .cfg_shift(cfg_shift), .sig_out(sig_out), .sig_valid(sig_valid));

    function automatic logic [31:0] conc(input logic [63:0] v, input logic [15:0] c);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            int idx = int'(c[k*4 +: 4]);
            if (idx < 8) r[k*8 +: 8] = v[idx*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [7:0] hash(input logic [31:0] x);
        logic [7:0] s = '0;
        for (int r = 0; r < 8; r++)
            for (int b = 0; b < 32; b++)
                if (ROWS[r][b]) s[r] ^= x[b];
        return s;
    endfunction

    task automatic check(input string req);
        checks++;
        if (sig_out !== e_sig || sig_valid !== e_valid) begin
            errors++;
            $display("FAIL %s: sig=%h valid=%b expected sig=%h valid=%b",
                     req, sig_out, sig_valid, e_sig, e_valid);
        end
    endtask

    task automatic cyc(input logic [63:0] v, input logic en, input logic sh,
                       input logic sdi, input string req);
        @(negedge clk);
        mon_vec = v; mon_en = en; cfg_shift = sh; cfg_sdi = sdi;
        @(posedge clk);
        #1;
        if (sh) begin
            m_cfg = {sdi, m_cfg[15:1]};
            e_valid = 1'b0;
        end else begin
            e_valid = en;
            if (en) e_sig = hash(conc(v, m_cfg));
        end
        check(req);
    endtask

    task automatic load(input logic [15:0] c, input logic en_during);
        for (int i = 0; i < 16; i++)
            cyc({$urandom, $urandom}, en_during, 1'b1, c[i], "R8");
    endtask

    initial begin
        m_cfg = 16'h3210;
        e_sig = '0;
        e_valid = 1'b0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, then identity routing
        cyc(64'h0, 1'b0, 1'b0, 1'b0, "R1");
        cyc(64'h8877665544332211, 1'b1, 1'b0, 1'b0, "R1");
        // R4: single-bit vectors reveal each row's taps
        for (int b = 0; b < 32; b += 5)
            cyc(64'h1 << b, 1'b1, 1'b0, 1'b0, "R4");
        // R6: idle holds
        cyc(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, "R6");
        cyc(64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b0, "R6");
        // R2: routing upper words with a duplicate
        load(16'h7755, 1'b1);
        cyc(64'hA1B2C3D4E5F60718, 1'b1, 1'b0, 1'b0, "R7");
        cyc(64'h5A5A_0000_FFFF_1234, 1'b1, 1'b0, 1'b0, "R2");
        // R3: out-of-range indices 8 and 15 give zero slots
        load(16'hF28B, 1'b0);
        cyc(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, "R3");
        cyc(64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0, 1'b0, "R3");
        // R9: linearity under a fixed routing
        load(16'h4163, 1'b1);
        for (int t = 0; t < 6; t++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            logic [7:0]  sa, sb;
            cyc(a, 1'b1, 1'b0, 1'b0, "R5"); sa = sig_out;
            cyc(b, 1'b1, 1'b0, 1'b0, "R5"); sb = sig_out;
            cyc(a ^ b, 1'b1, 1'b0, 1'b0, "R9");
            checks++;
            if (sig_out !== (sa ^ sb)) begin
                errors++;
                $display("FAIL R9: sig=%h expected=%h", sig_out, sa ^ sb);
            end
        end
        // R5/R6/R7/R8: random mix with occasional reloads
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 39) == 0) load(16'($urandom), 1'($urandom));
            else cyc({$urandom, $urandom}, ($urandom_range(0, 9) < 8), 1'b0, 1'b0, "R5");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule